// File: doc/BRIEF.md
# AGC Gain Step Pacer

This block sets the pace of an automatic gain control loop. A level detector outside the block reports, every clock, whether the signal sits above the target level. A free-running base-time tick, also made outside, gives the unit of time. From these two inputs the block keeps a 5-bit gain-step index in the range 0 to 31. While the level is too high, the index walks down, which is the attack. Once the level has stayed at or below target for a programmable hold time, the index walks back up, which is the decay. The gain multiplier downstream reads the index and turns it into a real gain.

Timing is set by three 4-bit exponential codes. The hold code sets the hold time. The attack and decay codes set the time to sweep the whole 32-step range, so the block divides each by 32 to get the time per step. A 4-bit target code is stored next to them and driven out as the target level, counted in 1.5 dB steps below full scale. All codes are loaded together by a one-cycle write strobe. Every pin is a plain level or strobe. No pin uses a handshake, so there is no back-pressure.

Top module: `agc_pacer`

## Requirements
- R1: After reset, gain_o is 31 and target_o is 2. The stored hold code resets to 2, and the attack and decay codes reset to 0.
- R2: In the cycle after a write strobe, target_o equals the target code that was written. Code k stands for -1.5*k dB, so 0 is 0 dB and 15 is -22.5 dB. target_o changes at no other time.
- R3: While above_i is high, gain_o drops by one for every 2^(a+4) ticks, where a is the attack code. The first drop comes 2^(a+4) ticks after the cycle in which above_i is first seen high. The index stops at 0.
- R4: An attack code above 10 times the same as 10, which is 16384 ticks per step.
- R5: After above_i falls, a hold of 2^(h+6) ticks runs, where h is the hold code. After the hold, gain_o rises by one for every 2^(d+6) ticks, where d is the decay code. The index stops at 31. With default codes, the first rise comes 320 ticks after the cycle in which the fall is seen.
- R6: If above_i goes high during the hold or during decay, the hold is dropped and attack starts in that same cycle with a fresh count. The phase change takes priority over a tick in the same cycle, so no step happens in that cycle.
- R7: The interval counters advance only on cycles with tick_i high. Without ticks, gain_o does not change. A phase change still takes effect on a cycle with no tick.
- R8: New timing codes take effect at the next step boundary or phase change. An interval already in progress finishes with the length it started with.
- R9: gain_o moves by at most one step per cycle. It falls only after a cycle with above_i and tick_i both high. It rises only after a cycle with above_i low and tick_i high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Base-time tick, one cycle wide |
| above_i | input | 1 | Level is above the target, from the detector |
| cfg_wr_i | input | 1 | Write strobe that loads all four codes |
| cfg_target_i | input | 4 | Target level code, in 1.5 dB steps down |
| cfg_delay_i | input | 4 | Hold code: 2^(code+6) ticks |
| cfg_attack_i | input | 4 | Attack code: full sweep is 2^(code+9) ticks, clamped at 10 |
| cfg_decay_i | input | 4 | Decay code: full sweep is 2^(code+11) ticks |
| gain_o | output | 5 | Gain-step index, 31 is maximum gain |
| target_o | output | 4 | Stored target level code |

## Verification
A change of phase and the end of an interval can fall on the same clock edge. The bench forces this case directly. It lets a decay interval run to its last count, then raises the level flag on the very tick that would have stepped the gain up. It then checks that the index stays put in that cycle and that the next drop comes a full attack interval later. In the same way, a code write landing partway through a 16384-tick attack interval is judged by checking that the interval still ends on its old length. Only the interval after it uses the new length.

// File: rtl/agc_pacer_pkg.sv
package agc_pacer_pkg;
  localparam int CODE_W = 4;

  typedef enum logic [1:0] {
    PH_ATTACK = 2'd0,
    PH_HOLD   = 2'd1,
    PH_DECAY  = 2'd2
  } phase_t;

  typedef struct packed {
    logic [CODE_W-1:0] hold;
    logic [CODE_W-1:0] attack;
    logic [CODE_W-1:0] decay;
  } tcodes_t;
endpackage

// File: rtl/agc_cfg_regs.sv
module agc_cfg_regs
  import agc_pacer_pkg::*;
#(
  parameter int RST_TARGET = 2,
  parameter int RST_HOLD   = 2,
  parameter int RST_ATTACK = 0,
  parameter int RST_DECAY  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [CODE_W-1:0] target_i,
  input  tcodes_t           codes_i,
  output logic [CODE_W-1:0] target_o,
  output tcodes_t           codes_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      target_o       <= CODE_W'(RST_TARGET);
      codes_o.hold   <= CODE_W'(RST_HOLD);
      codes_o.attack <= CODE_W'(RST_ATTACK);
      codes_o.decay  <= CODE_W'(RST_DECAY);
    end else if (wr_i) begin
      target_o <= target_i;
      codes_o  <= codes_i;
    end
  end
endmodule

// File: rtl/agc_len_calc.sv
module agc_len_calc
  import agc_pacer_pkg::*;
#(
  parameter int CNT_W     = 22,
  parameter int BASE_EXP  = 6,
  parameter int DIV_EXP   = 0,
  parameter int CODE_CLIP = 15
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [CNT_W-1:0]  last_o
);
  localparam int unsigned OFFSET = unsigned'(BASE_EXP - DIV_EXP);
  localparam int CODE_MAX = (1 << CODE_W) - 1;

  logic [CODE_W-1:0] eff;

  generate
    if (CODE_CLIP < CODE_MAX) begin : g_clip
      assign eff = (code_i > CODE_W'(CODE_CLIP)) ? CODE_W'(CODE_CLIP) : code_i;
    end else begin : g_plain
      assign eff = code_i;
    end
  endgenerate

  assign last_o = (CNT_W'(1) << (32'(eff) + OFFSET)) - CNT_W'(1);
endmodule

// File: rtl/agc_step_seq.sv
module agc_step_seq
  import agc_pacer_pkg::*;
#(
  parameter int GAIN_W = 5,
  parameter int CNT_W  = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              above_i,
  input  logic [CNT_W-1:0]  att_last_i,
  input  logic [CNT_W-1:0]  hold_last_i,
  input  logic [CNT_W-1:0]  dec_last_i,
  output logic [GAIN_W-1:0] gain_o,
  output logic              boundary_o
);
  localparam logic [GAIN_W-1:0] GAIN_MAX = '1;

  phase_t           phase;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cur_last;
  logic             go_attack, go_hold, wrap;

  always_comb begin
    go_attack = above_i && (phase != PH_ATTACK);
    go_hold   = !above_i && (phase == PH_ATTACK);
    case (phase)
      PH_ATTACK: cur_last = att_last_i;
      PH_HOLD:   cur_last = hold_last_i;
      default:   cur_last = dec_last_i;
    endcase
    wrap       = tick_i && (cnt == cur_last);
    boundary_o = go_attack || go_hold || wrap;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase  <= PH_DECAY;
      cnt    <= '0;
      gain_o <= GAIN_MAX;
    end else if (go_attack) begin
      phase <= PH_ATTACK;
      cnt   <= '0;
    end else if (go_hold) begin
      phase <= PH_HOLD;
      cnt   <= '0;
    end else if (tick_i) begin
      if (wrap) begin
        cnt <= '0;
        case (phase)
          PH_ATTACK: if (gain_o != '0) gain_o <= gain_o - 1'b1;
          PH_HOLD:   phase <= PH_DECAY;
          default:   if (gain_o != GAIN_MAX) gain_o <= gain_o + 1'b1;
        endcase
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/agc_pacer.sv
module agc_pacer
  import agc_pacer_pkg::*;
#(
  parameter int STEPS_LOG2 = 5,
  parameter int HOLD_EXP   = 6,
  parameter int ATT_EXP    = 9,
  parameter int DEC_EXP    = 11,
  parameter int ATT_CLIP   = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick_i,
  input  logic                  above_i,
  input  logic                  cfg_wr_i,
  input  logic [3:0]            cfg_target_i,
  input  logic [3:0]            cfg_delay_i,
  input  logic [3:0]            cfg_attack_i,
  input  logic [3:0]            cfg_decay_i,
  output logic [STEPS_LOG2-1:0] gain_o,
  output logic [3:0]            target_o
);
  localparam int CODE_MAX  = (1 << CODE_W) - 1;
  localparam int SH_HOLD   = HOLD_EXP + CODE_MAX;
  localparam int SH_DEC    = DEC_EXP - STEPS_LOG2 + CODE_MAX;
  localparam int SH_ATT    = ATT_EXP - STEPS_LOG2 + ATT_CLIP;
  localparam int SH_HD     = (SH_HOLD > SH_DEC) ? SH_HOLD : SH_DEC;
  localparam int CNT_W     = ((SH_HD > SH_ATT) ? SH_HD : SH_ATT) + 1;

  tcodes_t          cfg_codes, act_codes, wr_codes;
  logic             boundary;
  logic [CNT_W-1:0] att_last, hold_last, dec_last;

  assign wr_codes = '{hold: cfg_delay_i, attack: cfg_attack_i, decay: cfg_decay_i};

  agc_cfg_regs u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_i     (cfg_wr_i),
    .target_i (cfg_target_i),
    .codes_i  (wr_codes),
    .target_o (target_o),
    .codes_o  (cfg_codes)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_codes.hold   <= CODE_W'(2);
      act_codes.attack <= '0;
      act_codes.decay  <= '0;
    end else if (boundary) begin
      act_codes <= cfg_codes;
    end
  end

  agc_len_calc #(.CNT_W(CNT_W), .BASE_EXP(HOLD_EXP), .DIV_EXP(0), .CODE_CLIP(CODE_MAX))
    u_hold_len (.code_i(act_codes.hold), .last_o(hold_last));

  agc_len_calc #(.CNT_W(CNT_W), .BASE_EXP(ATT_EXP), .DIV_EXP(STEPS_LOG2), .CODE_CLIP(ATT_CLIP))
    u_att_len (.code_i(act_codes.attack), .last_o(att_last));

  agc_len_calc #(.CNT_W(CNT_W), .BASE_EXP(DEC_EXP), .DIV_EXP(STEPS_LOG2), .CODE_CLIP(CODE_MAX))
    u_dec_len (.code_i(act_codes.decay), .last_o(dec_last));

  agc_step_seq #(.GAIN_W(STEPS_LOG2), .CNT_W(CNT_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick_i),
    .above_i     (above_i),
    .att_last_i  (att_last),
    .hold_last_i (hold_last),
    .dec_last_i  (dec_last),
    .gain_o      (gain_o),
    .boundary_o  (boundary)
  );
endmodule

// File: rtl/agc_pacer_chk.sv
module agc_pacer_chk #(
  parameter int GAIN_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_i,
  input logic              above_i,
  input logic              cfg_wr_i,
  input logic [3:0]        cfg_target_i,
  input logic [3:0]        cfg_delay_i,
  input logic [3:0]        cfg_attack_i,
  input logic [3:0]        cfg_decay_i,
  input logic [GAIN_W-1:0] gain_o,
  input logic [3:0]        target_o
);
  assert_drop_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_o < $past(gain_o)) |-> ($past(above_i) && $past(tick_i)));

  assert_rise_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_o > $past(gain_o)) |-> (!$past(above_i) && $past(tick_i)));

  assert_attack_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(above_i) |-> (gain_o <= $past(gain_o)));

  assert_idle_no_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tick_i) |-> $stable(gain_o));

  assert_one_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, gain_o} == {1'b0, $past(gain_o)}) ||
    ({1'b0, gain_o} == {1'b0, $past(gain_o)} + 1'b1) ||
    ({1'b0, gain_o} + 1'b1 == {1'b0, $past(gain_o)}));

  assert_target_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_wr_i) |-> (target_o == $past(cfg_target_i)));

  assert_target_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cfg_wr_i) |-> $stable(target_o));
endmodule

bind agc_pacer agc_pacer_chk #(.GAIN_W(STEPS_LOG2)) u_chk (.*);

// File: tb/tb_agc_pacer.sv
module tb_agc_pacer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_i = 1'b1;
  logic       above_i = 1'b0;
  logic       cfg_wr_i = 1'b0;
  logic [3:0] cfg_target_i = 4'd0;
  logic [3:0] cfg_delay_i = 4'd0;
  logic [3:0] cfg_attack_i = 4'd0;
  logic [3:0] cfg_decay_i = 4'd0;
  logic [4:0] gain_o;
  logic [3:0] target_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  agc_pacer dut (.*);

  // {req[3:0], above, tick, cycles[15:0], expected gain[4:0]}
  localparam int NV = 25;
  localparam logic [26:0] VEC [NV] = '{
    {4'd3, 1'b1, 1'b1, 16'd16,   5'd31}, // R3 no drop before first interval
    {4'd3, 1'b1, 1'b1, 16'd1,    5'd30}, // R3 first drop
    {4'd3, 1'b1, 1'b1, 16'd15,   5'd30}, // R3
    {4'd3, 1'b1, 1'b1, 16'd1,    5'd29}, // R3 second drop, 16 ticks later
    {4'd5, 1'b0, 1'b1, 16'd320,  5'd29}, // R5 hold 256 plus 63 decay ticks
    {4'd5, 1'b0, 1'b1, 16'd1,    5'd30}, // R5 first rise
    {4'd5, 1'b0, 1'b1, 16'd63,   5'd30}, // R5
    {4'd5, 1'b0, 1'b1, 16'd1,    5'd31}, // R5 second rise
    {4'd5, 1'b0, 1'b1, 16'd200,  5'd31}, // R5 held at maximum
    {4'd3, 1'b1, 1'b1, 16'd496,  5'd1},  // R3 long attack
    {4'd3, 1'b1, 1'b1, 16'd1,    5'd0},  // R3 reaches minimum
    {4'd3, 1'b1, 1'b1, 16'd100,  5'd0},  // R3 held at minimum
    {4'd7, 1'b0, 1'b0, 16'd1000, 5'd0},  // R7 no ticks, no movement
    {4'd7, 1'b0, 1'b1, 16'd319,  5'd0},  // R7 hold begins counting only now
    {4'd7, 1'b0, 1'b1, 16'd1,    5'd1},  // R7
    {4'd6, 1'b1, 1'b1, 16'd1,    5'd1},  // R6 enter attack
    {4'd6, 1'b0, 1'b1, 16'd100,  5'd1},  // R6 partway into hold
    {4'd6, 1'b1, 1'b1, 16'd16,   5'd1},  // R6 attack restarts fresh
    {4'd6, 1'b1, 1'b1, 16'd1,    5'd0},  // R6 drop after one full interval
    {4'd6, 1'b0, 1'b1, 16'd320,  5'd0},  // R6 next hold is full length
    {4'd6, 1'b0, 1'b1, 16'd1,    5'd1},  // R6
    {4'd6, 1'b0, 1'b1, 16'd63,   5'd1},  // R6 decay at its last count
    {4'd6, 1'b1, 1'b1, 16'd1,    5'd1},  // R6 phase change beats step
    {4'd6, 1'b1, 1'b1, 16'd15,   5'd1},  // R6
    {4'd6, 1'b1, 1'b1, 16'd1,    5'd0}   // R6
  };

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic run(input logic a, input logic t, input int n);
    above_i = a;
    tick_i  = t;
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic write_cfg(input logic [3:0] tg, input logic [3:0] hd,
                           input logic [3:0] at, input logic [3:0] dc);
    cfg_target_i = tg;
    cfg_delay_i  = hd;
    cfg_attack_i = at;
    cfg_decay_i  = dc;
    cfg_wr_i     = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cfg_wr_i = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 gain", gain_o, 31);
    check("R1 target", target_o, 2);

    for (int i = 0; i < NV; i++) begin
      run(VEC[i][22], VEC[i][21], int'(VEC[i][20:5]));
      check($sformatf("R%0d vector %0d", VEC[i][26:23], i), gain_o, VEC[i][4:0]);
    end

    // R2 target output follows writes
    write_cfg(4'd15, 4'd2, 4'd0, 4'd0);
    check("R2 target 15", target_o, 15);
    write_cfg(4'd0, 4'd2, 4'd0, 4'd0);
    check("R2 target 0", target_o, 0);

    // R5 hold code 0 (64 ticks), decay code 1 (128 ticks per step)
    write_cfg(4'd0, 4'd0, 4'd0, 4'd1);
    run(1'b0, 1'b1, 192);
    check("R5 short hold before rise", gain_o, 0);
    run(1'b0, 1'b1, 1);
    check("R5 short hold rise", gain_o, 1);
    run(1'b0, 1'b1, 256);
    check("R5 decay code 1", gain_o, 3);

    // R4 attack code 12 behaves as 10
    write_cfg(4'd0, 4'd0, 4'd12, 4'd1);
    run(1'b1, 1'b1, 16384);
    check("R4 clipped attack before drop", gain_o, 3);
    run(1'b1, 1'b1, 1);
    check("R4 clipped attack drop", gain_o, 2);

    // R8 write mid-interval: the running interval keeps its length
    write_cfg(4'd0, 4'd0, 4'd0, 4'd1);
    run(1'b1, 1'b1, 16382);
    check("R8 old interval still running", gain_o, 2);
    run(1'b1, 1'b1, 1);
    check("R8 old interval ends", gain_o, 1);
    run(1'b1, 1'b1, 15);
    check("R8 new interval before drop", gain_o, 1);
    run(1'b1, 1'b1, 1);
    check("R8 new interval drop", gain_o, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got %0d cycles expected completion", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule